// File: doc/BRIEF.md
# Converter Result Serial Output Port

This block hands finished conversion results from a data converter to a host over a three-wire serial link. When the converter core presents a new result word, the port takes it into an output holding register and drives an active-low ready flag to announce it. The host then selects the port with an active-low select line and clocks the word out most significant bit first. A new bit is presented after every falling edge of the shift clock, so the host samples on rising edges.

Two clocking schemes are supported and chosen by a static mode input. In self-clocked mode the port generates the shift clock from the master clock and drives it out. In host-clocked mode the host supplies the shift clock. The select line and the host clock are brought into the master-clock domain through two-flop synchronizers, and their edges are detected there. The master clock must run at least four times faster than the host shift clock.

If a word is never read, the ready flag is withdrawn two master-clock cycles before the following result lands, so the host can see where one result ends and the next begins. A result that arrives while a word is being shifted waits in a pending register until that word is finished. Dropping the select line in the middle of a word abandons the transfer. The word stays ready and is sent again from its top bit the next time the port is selected.

Top module: `serout_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `drdy_n` is 1, `sdata_oe` is 0 and `sclk_out` is 1.
- R2: A `res_valid` pulse sampled at clock edge E0 while no transfer is active drives `drdy_n` to 1 after E0 and keeps it at 1 after E1. `drdy_n` goes to 0 after E2, with the new word loaded. Any previously held, unread word is discarded.
- R3: In host-clocked mode (`mode_self` = 0), the held word appears on `sdata` MSB first, and the bit moves one place lower after each falling edge of `sclk_in`. The word ends on the `WORD_W`-th falling edge.
- R4: Once the last bit has been sent, `drdy_n` returns to 1 and `sdata_oe` returns to 0.
- R5: `sdata_oe` is 1 only while `cs_n` is low and a word is held. With `cs_n` high, `drdy_n` keeps its value and nothing is sent.
- R6: In self-clocked mode (`mode_self` = 1), `sclk_oe` is 1. `sclk_out` idles high and toggles only while a word is being sent with `cs_n` low. The first falling edge shows the MSB, each later falling edge presents the next bit, and the word ends on the `WORD_W`-th rising edge.
- R7: Raising `cs_n` mid-word drops `sdata_oe` within four master-clock cycles while `drdy_n` stays 0. The next selection resends the same word from its MSB.
- R8: A `res_valid` pulse that arrives during a transfer does not alter the word being sent. The new word is loaded after that transfer ends, with `drdy_n` high for at least two cycles before it falls again.
- R9: The generated shift clock has a period of `CLK_DIV` master-clock cycles, high and low for half of that each.
- R10: The word width is a parameter, 16 or 20 bits, and every bit of a 20-bit word reaches the host in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a new result word is present |
| res_word | input | WORD_W | Result word from the converter core |
| mode_self | input | 1 | 1: port generates the shift clock; 0: host supplies it |
| cs_n | input | 1 | Active-low select from the host (asynchronous) |
| sclk_in | input | 1 | Host shift clock (asynchronous, used when `mode_self` = 0) |
| drdy_n | output | 1 | Active-low ready flag for a held, unread word |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for `sdata`; 0 means high-impedance |
| sclk_out | output | 1 | Generated shift clock, idles high |
| sclk_oe | output | 1 | Output enable for `sclk_out`, equal to the mode select |

## Verification
The ready flag is sampled on the falling clock edges after E0, E1 and E2 of each strobe. It must read 1, 1 and then 0. Select and host-clock changes pass through two synchronizer flops and one edge-detect flop, so a new bit is due three master cycles after a host falling edge. The bench therefore samples `sdata` at the end of each six-cycle high phase, and checks the select-driven enable four cycles after `cs_n` moves. In self-clocked mode the bench counts rising edges of `sclk_out`, takes each bit from the last low-phase sample, and measures the interval between the second and third rises against `CLK_DIV`.

// File: rtl/serout_pkg.sv
// Package: shared types and helpers for the serial result output port.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package serout_pkg;

    // One-cycle shift-clock edge events in the master-clock domain.
    typedef struct packed {
        logic fall;
        logic rise;
    } serout_edge_t;

    // Master cycles per half period of the generated shift clock.
    function automatic int half_div(input int div);
        return (div < 4) ? 2 : div / 2;
    endfunction

    // Width of a counter that must reach n-1 (at least one bit).
    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/serout_sync.sv
// Module: multi-bit level synchronizer, one independent flop chain per bit.
// Assumes each bit is a slow level signal; no bus coherence across bits.
module serout_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;

            // Shift the asynchronous input through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
                else        chain_q <= {chain_q[STAGES-2:0], d[b]};
            end

            assign q[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/serout_clkgen.sv
// Module: shift-clock source. In self mode it divides the master clock and
// drives an idle-high clock while a transfer runs; in host mode it detects
// edges on the synchronized host clock. Either way it reports fall/rise events.
// Assumes CLK_DIV is even and at least 4.
module serout_clkgen
    import serout_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_self,
    input  logic         run,
    input  logic         ext_sclk_s,
    output logic         sclk_q,
    output serout_edge_t edges
);

    localparam int HALF  = half_div(CLK_DIV);
    localparam int CNT_W = cnt_bits(HALF);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ext_prev_q;
    logic             gen_on;
    logic             gen_toggle;

    assign gen_on     = mode_self && run;
    assign gen_toggle = gen_on && (cnt_q == CNT_TOP);

    // Divider: count half periods while running, park high otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (gen_on) begin
            if (gen_toggle) begin
                cnt_q  <= '0;
                sclk_q <= ~sclk_q;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end else begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end
    end

    // Keep last synchronized host clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b0;
        else        ext_prev_q <= ext_sclk_s;
    end

    // Select event source by mode.
    always_comb begin
        if (mode_self) begin
            edges.fall = gen_toggle && sclk_q;
            edges.rise = gen_toggle && !sclk_q;
        end else begin
            edges.fall = ext_prev_q && !ext_sclk_s;
            edges.rise = !ext_prev_q && ext_sclk_s;
        end
    end

    AST_GEN_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_self && $fell(sclk_q)) |-> $past(sclk_q, 2));  // R9

    AST_GEN_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_self && $rose(sclk_q) && $past(run)) |-> !$past(sclk_q, 2));  // R9

endmodule

// File: rtl/serout_ctrl.sv
// Module: word holding, ready flag and bit sequencing. Accepts result words
// through a two-cycle release/load pipeline, holds a word that arrives during
// a transfer, and walks the bit index MSB first on shift-clock events.
// Assumes cs_act and edges are already in the master-clock domain.
module serout_ctrl
    import serout_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_word,
    input  logic              mode_self,
    input  logic              cs_act,
    input  serout_edge_t      edges,
    output logic              drdy_n,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              run
);

    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WORD_W - 1);
    localparam logic [1:0]       LOAD_AT = 2'd2;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] pend_word_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        pend_cnt_q;
    logic              pend_v_q;
    logic              avail_q;
    logic              drdy_q;
    logic              first_q;
    logic              busy;
    logic              end_evt;
    logic              fin;
    logic              skip_fall;

    assign busy      = cs_act && avail_q;
    assign end_evt   = mode_self ? edges.rise : edges.fall;
    assign fin       = busy && end_evt && (idx_q == '0);
    assign skip_fall = mode_self && first_q;

    // Bit engine and result intake; the two act in disjoint busy states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q      <= '0;
            pend_word_q <= '0;
            idx_q       <= IDX_TOP;
            pend_cnt_q  <= '0;
            pend_v_q    <= 1'b0;
            avail_q     <= 1'b0;
            drdy_q      <= 1'b1;
            first_q     <= 1'b1;
        end else begin
            // Bit engine: restart on deselect, finish, or step on a fall.
            if (!busy) begin
                idx_q   <= IDX_TOP;
                first_q <= 1'b1;
            end else if (fin) begin
                avail_q <= 1'b0;
                drdy_q  <= 1'b1;
                idx_q   <= IDX_TOP;
                first_q <= 1'b1;
            end else if (edges.fall) begin
                first_q <= 1'b0;
                if (!skip_fall && idx_q != '0) idx_q <= idx_q - IDX_W'(1);
            end

            // Intake: capture, release the old word, then load two edges later.
            if (res_valid) begin
                pend_word_q <= res_word;
                pend_v_q    <= 1'b1;
                if (busy) begin
                    pend_cnt_q <= 2'd0;
                end else begin
                    pend_cnt_q <= 2'd1;
                    avail_q    <= 1'b0;
                    drdy_q     <= 1'b1;
                end
            end else if (pend_v_q && !busy) begin
                if (pend_cnt_q == LOAD_AT) begin
                    word_q   <= pend_word_q;
                    avail_q  <= 1'b1;
                    drdy_q   <= 1'b0;
                    pend_v_q <= 1'b0;
                    idx_q    <= IDX_TOP;
                end else begin
                    pend_cnt_q <= pend_cnt_q + 2'd1;
                    avail_q    <= 1'b0;
                    drdy_q     <= 1'b1;
                end
            end
        end
    end

    assign drdy_n   = drdy_q;
    assign sdata_oe = busy;
    assign sdata    = busy ? word_q[idx_q] : 1'b0;
    assign run      = busy;

    AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_q) |-> $past(drdy_q, 2));  // R2

    AST_IDX_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (idx_q != $past(idx_q))) |-> (idx_q == $past(idx_q) - IDX_W'(1)));  // R3

    AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> !drdy_n);  // R5

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(word_q));  // R8

endmodule

// File: rtl/serout_port.sv
// Module: top of the converter result serial output port. Synchronizes the
// host select and clock, picks the clock source by mode, and exposes the
// ready flag, serial data and clock with their output enables.
// Assumes WORD_W is 16 or 20, CLK_DIV even and >= 4, and the master clock at
// least four times the host shift clock.
module serout_port
    import serout_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [WORD_W-1:0] res_word,
    input  logic              mode_self,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              drdy_n,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              sclk_out,
    output logic              sclk_oe
);

    localparam int IDX_W = cnt_bits(WORD_W);

    logic         cs_n_s;
    logic         sclk_s;
    logic         cs_act;
    logic         run;
    serout_edge_t edges;

    serout_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, cs_n}),
        .q     ({sclk_s, cs_n_s})
    );

    assign cs_act = !cs_n_s;

    serout_clkgen #(
        .CLK_DIV (CLK_DIV)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_self  (mode_self),
        .run        (run),
        .ext_sclk_s (sclk_s),
        .sclk_q     (sclk_out),
        .edges      (edges)
    );

    serout_ctrl #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_word  (res_word),
        .mode_self (mode_self),
        .cs_act    (cs_act),
        .edges     (edges),
        .drdy_n    (drdy_n),
        .sdata     (sdata),
        .sdata_oe  (sdata_oe),
        .run       (run)
    );

    assign sclk_oe = mode_self;

    AST_SCLK_PARKED_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> sclk_out);  // R6

    AST_NO_OE_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !sdata_oe);  // R5

endmodule

// File: tb/serout_port_bench.sv
// Bench: directed corner cases plus seeded random words in both clock modes.
module serout_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 20;
    localparam int DIV        = 4;
    localparam int HALF_EXT   = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         res_valid;
    logic [W-1:0] res_word;
    logic         mode_self;
    logic         cs_n;
    logic         sclk_in;
    logic         drdy_n;
    logic         sdata;
    logic         sdata_oe;
    logic         sclk_out;
    logic         sclk_oe;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serout_port #(.WORD_W(W), .CLK_DIV(DIV), .SYNC_STAGES(2)) u_serout_port (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_word(res_word),
        .mode_self(mode_self), .cs_n(cs_n), .sclk_in(sclk_in),
        .drdy_n(drdy_n), .sdata(sdata), .sdata_oe(sdata_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe)
    );

    // Expected word as the host should reassemble it: low W bits, MSB first.
    function automatic logic [W-1:0] exp_word(input logic [31:0] r);
        return r[W-1:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Strobe a word while idle and check the release/load timing.
    task automatic strobe_check(input logic [W-1:0] w);
        @(negedge clk); res_valid = 1'b1; res_word = w;
        @(negedge clk); res_valid = 1'b0;
        chk("R2 drdy_n after E0", 32'(drdy_n), 1);
        @(negedge clk);
        chk("R2 drdy_n after E1", 32'(drdy_n), 1);
        @(negedge clk);
        chk("R2 drdy_n after E2", 32'(drdy_n), 0);
    endtask

    // Host-clocked read; optionally strobes a new word during bit strobe_at.
    task automatic read_ext(input int strobe_at, input logic [W-1:0] sw,
                            input bit chk_end, output logic [W-1:0] got);
        got = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 sdata_oe while selected", 32'(sdata_oe), 1);
        for (int i = 0; i < W; i++) begin
            sclk_in = 1'b1;
            for (int h = 0; h < HALF_EXT; h++) begin
                @(negedge clk);
                res_valid = (i == strobe_at) && (h == 0);
                if (i == strobe_at && h == 0) res_word = sw;
            end
            if (i == strobe_at) chk("R8 drdy_n held during transfer", 32'(drdy_n), 0);
            got = {got[W-2:0], sdata};
            sclk_in = 1'b0;
            repeat (HALF_EXT) @(negedge clk);
        end
        if (chk_end) begin
            chk("R4 drdy_n after last bit", 32'(drdy_n), 1);
            chk("R4 sdata_oe after last bit", 32'(sdata_oe), 0);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Self-clocked read: bit taken from last low-phase sample at each rise.
    task automatic read_self(output logic [W-1:0] got, output int per);
        int   nr = 0;
        int   t  = 0;
        int   r2 = 0;
        int   r3 = 0;
        logic prev = 1'b1;
        logic last_low = 1'b0;
        got = '0;
        @(negedge clk); cs_n = 1'b0;
        while (nr < W && t < 2000) begin
            @(negedge clk);
            t++;
            if (!prev && sclk_out) begin
                got = {got[W-2:0], last_low};
                nr++;
                if (nr == 2) r2 = t;
                if (nr == 3) r3 = t;
            end
            if (!sclk_out) last_low = sdata;
            prev = sclk_out;
        end
        per = r3 - r2;
        repeat (4) @(negedge clk);
        chk("R4 drdy_n after self read", 32'(drdy_n), 1);
        chk("R4 sdata_oe after self read", 32'(sdata_oe), 0);
        chk("R6 sclk_out idle after self read", 32'(sclk_out), 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] got;
        logic [W-1:0] wa;
        logic [W-1:0] wb;
        int           per;
        int           seed;
        seed = $urandom(32'd2718);
        rst_n = 1'b0; res_valid = 1'b0; res_word = '0;
        mode_self = 1'b0; cs_n = 1'b1; sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 drdy_n in reset", 32'(drdy_n), 1);
        chk("R1 sdata_oe in reset", 32'(sdata_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drdy_n after reset", 32'(drdy_n), 1);
        chk("R1 sclk_out after reset", 32'(sclk_out), 1);
        chk("R1 sdata_oe after reset", 32'(sdata_oe), 0);

        // Basic host-clocked read of a 20-bit word.
        strobe_check(20'hA5C3F);
        read_ext(-1, '0, 1'b1, got);
        chk("R3 R10 host-clocked word", 32'(got), 32'(exp_word(32'hA5C3F)));

        // Unread word withdrawn by the next result; select high sends nothing.
        strobe_check(20'h12345);
        strobe_check(20'h80001);
        repeat (10) @(negedge clk);
        chk("R5 sdata_oe with cs_n high", 32'(sdata_oe), 0);
        chk("R5 drdy_n kept with cs_n high", 32'(drdy_n), 0);
        read_ext(-1, '0, 1'b1, got);
        chk("R2 newest word delivered", 32'(got), 32'(exp_word(32'h80001)));

        // Abort mid-word, then full resend from the MSB.
        strobe_check(20'h3C96E);
        @(negedge clk); cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            sclk_in = 1'b1; repeat (HALF_EXT) @(negedge clk);
            sclk_in = 1'b0; repeat (HALF_EXT) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 sdata_oe after abort", 32'(sdata_oe), 0);
        chk("R7 drdy_n after abort", 32'(drdy_n), 0);
        read_ext(-1, '0, 1'b1, got);
        chk("R7 resent word after abort", 32'(got), 32'(exp_word(32'h3C96E)));

        // New result during a transfer is held until the word completes.
        strobe_check(20'hFFFF0);
        read_ext(8, 20'h0F0F5, 1'b0, got);
        chk("R8 word in flight unchanged", 32'(got), 32'(exp_word(32'hFFFF0)));
        chk("R8 pending word now ready", 32'(drdy_n), 0);
        read_ext(-1, '0, 1'b1, got);
        chk("R8 pending word delivered", 32'(got), 32'(exp_word(32'h0F0F5)));

        // Self-clocked read.
        @(negedge clk); mode_self = 1'b1;
        @(negedge clk);
        chk("R6 sclk_oe in self mode", 32'(sclk_oe), 1);
        strobe_check(20'h6B2D9);
        repeat (8) @(negedge clk);
        chk("R6 sclk_out parked while unselected", 32'(sclk_out), 1);
        read_self(got, per);
        chk("R6 R10 self-clocked word", 32'(got), 32'(exp_word(32'h6B2D9)));
        chk("R9 generated clock period", 32'(per), 32'(DIV));

        // Seeded random words in random modes.
        for (int k = 0; k < 30; k++) begin
            wa = W'($urandom());
            wb = W'($urandom());
            @(negedge clk); mode_self = $urandom() % 2;
            @(negedge clk);
            chk("R6 sclk_oe follows mode", 32'(sclk_oe), 32'(mode_self));
            strobe_check(wa);
            if (mode_self) begin
                read_self(got, per);
                chk("R6 random self word", 32'(got), 32'(exp_word(32'(wa))));
                chk("R9 random self period", 32'(per), 32'(DIV));
            end else if (k % 3 == 0) begin
                read_ext(int'($urandom() % (W - 2)) + 1, wb, 1'b0, got);
                chk("R8 random word in flight", 32'(got), 32'(exp_word(32'(wa))));
                read_ext(-1, '0, 1'b1, got);
                chk("R8 random pending word", 32'(got), 32'(exp_word(32'(wb))));
            end else begin
                read_ext(-1, '0, 1'b1, got);
                chk("R3 random host word", 32'(got), 32'(exp_word(32'(wa))));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule